// File: doc/BRIEF.md
# ECC Write-Path Error Injector

This unit sits between the ECC encoder and the DRAM command path of a memory controller. Every encoded write passes through it with one register stage of delay. When the unit is armed and a write's decoded location matches the programmed pattern, it corrupts the stored codeword or the address/command parity on purpose. The error-detection and reporting logic further down the path can then be exercised with errors of a known position and kind.

Software programs six location fields: module within a channel, rank, channel, bank, page and column. Each field is either an exact value or a wildcard. It also programs a flip mask, a target selector for the two halves of the codeword, and a kind selector. Then it arms the unit. An injection can fire once and disarm the unit, or it can repeat on every matching write until software disarms it. Each injection raises a one-cycle pulse and advances a saturating counter.

Top module: `ecc_inject_unit`

## Requirements
- R1: Reset state. All six location fields read back as wildcard, with bit 31 set and value 0. Mask, target, kind and arm read 0. `out_valid`, `inj_pulse` and `inj_count` are 0.
- R2: Passthrough. Each `wr_valid` cycle appears on `out_valid` one clock later. When no injection fires, `out_code` and `out_par` equal the inputs of that write.
- R3: Match. An injection fires only for a valid write while the unit is armed, and only if every field whose bit 31 is clear equals the request field.
- R4: Target. The 144-bit codeword is two 72-bit halves: lower is bits 71:0 and upper is bits 143:72. Target bit 0 selects the lower half and target bit 1 the upper half. Mask bit i flips bit i of each selected half; mask 64 flips bit 6 or bit 78. A target of 0 flips no data bits, but the injection still counts.
- R5: Kind. Kind bit 0 is repeat, bit 1 is data/check corruption and bit 2 is parity corruption. With only bit 2 set, `out_par` is inverted and the data is left alone. With bits 1 and 2 both set, both are corrupted. If neither bit 1 nor bit 2 is set, no injection fires.
- R6: One-shot. With the repeat bit clear, one injection clears the armed state. Later matching writes pass through untouched.
- R7: Repeat. With the repeat bit set, every matching write is corrupted until zero is written to the arm register.
- R8: Arm register. Writing any nonzero value arms the unit and reads back as 1. Writing zero disarms it. A write to the arm register in the same cycle as a one-shot injection takes precedence over the automatic disarm.
- R9: Register readback. The register map is: location fields at 0 to 5 (module, rank, channel, bank, page, column), target at 6, kind at 7, arm at 8, and mask words at 9 to 11, least significant first. `cfg_rdata` shows the register at `cfg_addr` one clock later. Value bits above a field's width read 0, and unused addresses read 0.
- R10: Injection report. `inj_pulse` is high for exactly the output cycle that carries the injected write. `inj_count` counts injections and holds at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered readback of `cfg_addr` |
| wr_valid | input | 1 | Write request present |
| wr_dimm | input | 2 | Module index within the channel |
| wr_rank | input | 2 | Rank |
| wr_chan | input | 2 | Channel |
| wr_bank | input | 4 | Bank |
| wr_page | input | 16 | Page (row) |
| wr_col | input | 12 | Column |
| wr_code | input | 144 | Encoded codeword |
| wr_par | input | 1 | Address/command parity |
| out_valid | output | 1 | Delayed write request |
| out_code | output | 144 | Codeword, possibly corrupted |
| out_par | output | 1 | Parity, possibly inverted |
| inj_pulse | output | 1 | Injection happened on this output |
| inj_count | output | 8 | Saturating injection count |

## Verification
The bound checker verifies every cycle the properties that local state is enough to decide:
- the one-cycle passthrough of un-injected writes;
- that each pulse follows a valid write while armed;
- that a parity-only injection leaves the data intact;
- one-shot disarm;
- counter stepping and saturation.

The location match against wildcards, the exact bit positions each target code flips, register readback and the priority of an arm write over a same-cycle disarm need the bench's reference model. That model is compared on every clock. Directed scenarios steer it through mismatching fields, all four target codes, every kind combination and 260 repeated injections.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  localparam int REG_W    = 32;
  localparam int RA_W     = 4;
  localparam int N_FIELDS = 6;
  localparam int ANY_BIT  = 31;

  localparam logic [RA_W-1:0] RA_SECT  = 4'd6;
  localparam logic [RA_W-1:0] RA_KIND  = 4'd7;
  localparam logic [RA_W-1:0] RA_ARM   = 4'd8;
  localparam logic [RA_W-1:0] RA_MASK0 = 4'd9;

  localparam int KB_REPEAT = 0;
  localparam int KB_DATA   = 1;
  localparam int KB_PAR    = 2;

  typedef logic [REG_W-1:0]   word_t;
  typedef logic [ANY_BIT-1:0] fval_t;
endpackage

// File: rtl/inj_regfile.sv
module inj_regfile
  import ecc_inj_pkg::*;
#(
  parameter int DIMM_W = 2,
  parameter int RANK_W = 2,
  parameter int CHAN_W = 2,
  parameter int BANK_W = 4,
  parameter int PAGE_W = 16,
  parameter int COL_W  = 12,
  parameter int SEC_W  = 72
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [RA_W-1:0]  cfg_addr,
  input  word_t            cfg_wdata,
  input  logic             fire,
  output word_t            match_q [N_FIELDS],
  output logic [SEC_W-1:0] mask,
  output logic [1:0]       sect,
  output logic [2:0]       kind,
  output logic             armed,
  output word_t            cfg_rdata
);
  localparam int MASK_REGS = (SEC_W + REG_W - 1) / REG_W;
  localparam int FW [N_FIELDS] = '{DIMM_W, RANK_W, CHAN_W, BANK_W, PAGE_W, COL_W};

  function automatic word_t keep_of(input int w);
    return word_t'((64'd1 << w) - 64'd1) | (word_t'(1) << ANY_BIT);
  endfunction

  word_t rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_FIELDS; i++) match_q[i] <= word_t'(1) << ANY_BIT;
      mask  <= '0;
      sect  <= '0;
      kind  <= '0;
      armed <= 1'b0;
    end else begin
      for (int i = 0; i < N_FIELDS; i++)
        if (cfg_we && cfg_addr == RA_W'(i)) match_q[i] <= cfg_wdata & keep_of(FW[i]);
      for (int k = 0; k < MASK_REGS; k++)
        for (int b = 0; b < REG_W; b++)
          if (cfg_we && cfg_addr == RA_MASK0 + RA_W'(k) && (k * REG_W + b) < SEC_W)
            mask[k*REG_W+b] <= cfg_wdata[b];
      if (cfg_we && cfg_addr == RA_SECT) sect <= cfg_wdata[1:0];
      if (cfg_we && cfg_addr == RA_KIND) kind <= cfg_wdata[2:0];
      // an explicit arm write outranks the one-shot disarm
      if (cfg_we && cfg_addr == RA_ARM) armed <= |cfg_wdata;
      else if (fire && !kind[KB_REPEAT]) armed <= 1'b0;
    end
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < N_FIELDS; i++)
      if (cfg_addr == RA_W'(i)) rd_next = match_q[i];
    if (cfg_addr == RA_SECT) rd_next = word_t'(sect);
    if (cfg_addr == RA_KIND) rd_next = word_t'(kind);
    if (cfg_addr == RA_ARM)  rd_next = word_t'(armed);
    for (int k = 0; k < MASK_REGS; k++)
      if (cfg_addr == RA_MASK0 + RA_W'(k))
        for (int b = 0; b < REG_W; b++)
          if ((k * REG_W + b) < SEC_W) rd_next[b] = mask[k*REG_W+b];
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_next;
  end
endmodule

// File: rtl/inj_addr_match.sv
module inj_addr_match
  import ecc_inj_pkg::*;
(
  input  word_t match_q [N_FIELDS],
  input  fval_t req_f   [N_FIELDS],
  output logic  hit
);
  logic [N_FIELDS-1:0] fld_ok;

  generate
    for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
      assign fld_ok[i] = match_q[i][ANY_BIT] | (match_q[i][ANY_BIT-1:0] == req_f[i]);
    end
  endgenerate

  assign hit = &fld_ok;
endmodule

// File: rtl/inj_corrupt.sv
module inj_corrupt #(
  parameter int SEC_W   = 72,
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  input  logic [2*SEC_W-1:0] wr_code,
  input  logic               wr_par,
  input  logic               fire,
  input  logic               flip_data,
  input  logic               flip_par,
  input  logic [1:0]         sect,
  input  logic [SEC_W-1:0]   mask,
  output logic               out_valid,
  output logic [2*SEC_W-1:0] out_code,
  output logic               out_par,
  output logic               inj_pulse,
  output logic [COUNT_W-1:0] inj_count
);
  localparam logic [COUNT_W-1:0] CNT_MAX = '1;

  logic [2*SEC_W-1:0] flip_vec;

  generate
    for (genvar s = 0; s < 2; s++) begin : g_sec
      assign flip_vec[s*SEC_W +: SEC_W] = (flip_data && sect[s]) ? mask : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
      out_par   <= 1'b0;
      inj_pulse <= 1'b0;
      inj_count <= '0;
    end else begin
      out_valid <= wr_valid;
      out_code  <= wr_code ^ flip_vec;
      out_par   <= wr_par ^ flip_par;
      inj_pulse <= fire;
      if (fire && inj_count != CNT_MAX) inj_count <= inj_count + 1'b1;
    end
  end
endmodule

// File: rtl/ecc_inject_unit.sv
module ecc_inject_unit
  import ecc_inj_pkg::*;
#(
  parameter int DIMM_W  = 2,
  parameter int RANK_W  = 2,
  parameter int CHAN_W  = 2,
  parameter int BANK_W  = 4,
  parameter int PAGE_W  = 16,
  parameter int COL_W   = 12,
  parameter int SEC_W   = 72,
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [3:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic               wr_valid,
  input  logic [DIMM_W-1:0]  wr_dimm,
  input  logic [RANK_W-1:0]  wr_rank,
  input  logic [CHAN_W-1:0]  wr_chan,
  input  logic [BANK_W-1:0]  wr_bank,
  input  logic [PAGE_W-1:0]  wr_page,
  input  logic [COL_W-1:0]   wr_col,
  input  logic [2*SEC_W-1:0] wr_code,
  input  logic               wr_par,
  output logic               out_valid,
  output logic [2*SEC_W-1:0] out_code,
  output logic               out_par,
  output logic               inj_pulse,
  output logic [COUNT_W-1:0] inj_count
);
  word_t            match_q [N_FIELDS];
  fval_t            req_f   [N_FIELDS];
  logic [SEC_W-1:0] mask;
  logic [1:0]       sect;
  logic [2:0]       kind;
  logic             armed;
  logic             hit;
  logic             fire;

  assign req_f[0] = fval_t'(wr_dimm);
  assign req_f[1] = fval_t'(wr_rank);
  assign req_f[2] = fval_t'(wr_chan);
  assign req_f[3] = fval_t'(wr_bank);
  assign req_f[4] = fval_t'(wr_page);
  assign req_f[5] = fval_t'(wr_col);

  assign fire = wr_valid && armed && hit && (kind[KB_DATA] || kind[KB_PAR]);

  inj_regfile #(
    .DIMM_W(DIMM_W), .RANK_W(RANK_W), .CHAN_W(CHAN_W),
    .BANK_W(BANK_W), .PAGE_W(PAGE_W), .COL_W(COL_W), .SEC_W(SEC_W)
  ) regs_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .fire(fire), .match_q(match_q), .mask(mask),
    .sect(sect), .kind(kind), .armed(armed), .cfg_rdata(cfg_rdata)
  );

  inj_addr_match match_i (
    .match_q(match_q), .req_f(req_f), .hit(hit)
  );

  inj_corrupt #(.SEC_W(SEC_W), .COUNT_W(COUNT_W)) corrupt_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_code(wr_code),
    .wr_par(wr_par), .fire(fire), .flip_data(fire && kind[KB_DATA]),
    .flip_par(fire && kind[KB_PAR]), .sect(sect), .mask(mask),
    .out_valid(out_valid), .out_code(out_code), .out_par(out_par),
    .inj_pulse(inj_pulse), .inj_count(inj_count)
  );
endmodule

// File: rtl/ecc_inject_chk.sv
module ecc_inject_chk
  import ecc_inj_pkg::*;
#(
  parameter int SEC_W   = 72,
  parameter int COUNT_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_valid,
  input logic [2*SEC_W-1:0] wr_code,
  input logic               wr_par,
  input logic               cfg_we,
  input logic [3:0]         cfg_addr,
  input logic               out_valid,
  input logic [2*SEC_W-1:0] out_code,
  input logic               out_par,
  input logic               inj_pulse,
  input logic [COUNT_W-1:0] inj_count,
  input logic               armed,
  input logic [2:0]         inj_kind
);
  localparam logic [COUNT_W-1:0] CNT_MAX = '1;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_valid) && !$past(rst)) |-> out_valid);

  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !inj_pulse) |-> (out_code == $past(wr_code) && out_par == $past(wr_par)));

  // R3
  armed_prior_chk: assert property (@(posedge clk) disable iff (rst)
    inj_pulse |-> ($past(armed) && $past(wr_valid)));

  // R5
  par_only_chk: assert property (@(posedge clk) disable iff (rst)
    (inj_pulse && $past(inj_kind[2:1]) == 2'b10)
      |-> (out_code == $past(wr_code) && out_par != $past(wr_par)));

  // R6
  oneshot_chk: assert property (@(posedge clk) disable iff (rst)
    (inj_pulse && !$past(inj_kind[0]) && !$past(cfg_we && cfg_addr == RA_ARM)) |-> !armed);

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inj_pulse && $past(inj_count) != CNT_MAX) |-> inj_count == COUNT_W'($past(inj_count) + 1'b1));

  // R10
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inj_pulse |-> $stable(inj_count));
endmodule

bind ecc_inject_unit ecc_inject_chk #(.SEC_W(SEC_W), .COUNT_W(COUNT_W)) chk_i (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_code(wr_code), .wr_par(wr_par),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .out_valid(out_valid), .out_code(out_code),
  .out_par(out_par), .inj_pulse(inj_pulse), .inj_count(inj_count),
  .armed(armed), .inj_kind(kind)
);

// File: tb/ecc_inject_unit_tb_top.sv
module ecc_inject_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_we = 1'b0;
  logic [3:0]   cfg_addr = '0;
  logic [31:0]  cfg_wdata = '0;
  logic [31:0]  cfg_rdata;
  logic         wr_valid = 1'b0;
  logic [1:0]   wr_dimm = '0, wr_rank = '0, wr_chan = '0;
  logic [3:0]   wr_bank = '0;
  logic [15:0]  wr_page = '0;
  logic [11:0]  wr_col = '0;
  logic [143:0] wr_code = '0;
  logic         wr_par = 1'b0;
  logic         out_valid, out_par, inj_pulse;
  logic [143:0] out_code;
  logic [7:0]   inj_count;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  ecc_inject_unit dut_i (.*);

  // ---------------- reference model ----------------
  localparam int FWL [6] = '{2, 2, 2, 4, 16, 12};
  int          m_val [6];
  bit          m_any [6];
  logic [71:0] m_mask;
  logic [1:0]  m_sect;
  logic [2:0]  m_kind;
  bit          m_armed;
  int          m_cnt;
  logic         e_valid, e_par, e_pulse;
  logic [143:0] e_code;
  logic [31:0]  e_rdata;

  function automatic logic [31:0] model_read(input logic [3:0] a);
    if (a < 6)   return {m_any[a], 31'(m_val[a])};
    if (a == 6)  return 32'(m_sect);
    if (a == 7)  return 32'(m_kind);
    if (a == 8)  return 32'(m_armed);
    if (a == 9)  return m_mask[31:0];
    if (a == 10) return m_mask[63:32];
    if (a == 11) return {24'd0, m_mask[71:64]};
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 6; i++) begin m_val[i] = 0; m_any[i] = 1; end
      m_mask = '0; m_sect = '0; m_kind = '0; m_armed = 0; m_cnt = 0;
      e_valid = 0; e_par = 0; e_pulse = 0; e_code = '0; e_rdata = '0;
    end else begin
      int  req [6];
      bit  hit, fire;
      logic [143:0] code;
      req[0] = int'(wr_dimm); req[1] = int'(wr_rank); req[2] = int'(wr_chan);
      req[3] = int'(wr_bank); req[4] = int'(wr_page); req[5] = int'(wr_col);
      hit = 1;
      for (int i = 0; i < 6; i++) if (!m_any[i] && m_val[i] != req[i]) hit = 0;
      fire = wr_valid && m_armed && hit && (m_kind[1] || m_kind[2]);
      code = wr_code;
      if (fire && m_kind[1]) begin
        if (m_sect[0]) code[71:0]   = code[71:0]   ^ m_mask;
        if (m_sect[1]) code[143:72] = code[143:72] ^ m_mask;
      end
      e_valid = wr_valid; e_code = code; e_par = wr_par ^ (fire && m_kind[2]);
      e_pulse = fire;
      if (fire && m_cnt < 255) m_cnt++;
      e_rdata = model_read(cfg_addr);
      if (cfg_we) begin
        if (cfg_addr < 6) begin
          m_any[cfg_addr] = cfg_wdata[31];
          m_val[cfg_addr] = int'(cfg_wdata[30:0]) & ((1 << FWL[cfg_addr]) - 1);
        end
        else if (cfg_addr == 6)  m_sect = cfg_wdata[1:0];
        else if (cfg_addr == 7)  m_kind = cfg_wdata[2:0];
        else if (cfg_addr == 8)  m_armed = (cfg_wdata != 0);
        else if (cfg_addr == 9)  m_mask[31:0]  = cfg_wdata;
        else if (cfg_addr == 10) m_mask[63:32] = cfg_wdata;
        else if (cfg_addr == 11) m_mask[71:64] = cfg_wdata[7:0];
      end else if (fire && !m_kind[0]) m_armed = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [143:0] act, input logic [143:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(out_valid === e_valid, "R2", "out_valid", 144'(out_valid), 144'(e_valid));
      chk(out_code === e_code, "R4", "out_code", out_code, e_code);
      chk(out_par === e_par, "R5", "out_par", 144'(out_par), 144'(e_par));
      chk(inj_pulse === e_pulse, "R10", "inj_pulse", 144'(inj_pulse), 144'(e_pulse));
      chk(inj_count === 8'(m_cnt), "R10", "inj_count", 144'(inj_count), 144'(m_cnt));
      chk(cfg_rdata === e_rdata, "R9", "cfg_rdata", 144'(cfg_rdata), 144'(e_rdata));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a;
    @(negedge clk); d = cfg_rdata;
  endtask

  task automatic req(input logic [1:0] rk, input logic [3:0] bk, input logic [15:0] pg,
                     input logic [143:0] code, input logic par,
                     output logic pulse, output logic [143:0] oc, output logic op);
    @(negedge clk);
    wr_valid = 1; wr_dimm = 2'd1; wr_rank = rk; wr_chan = 2'd0;
    wr_bank = bk; wr_page = pg; wr_col = 12'h0A5; wr_code = code; wr_par = par;
    @(negedge clk);
    wr_valid = 0;
    pulse = inj_pulse; oc = out_code; op = out_par;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=%0d cycles expected=completion", cyc);
      finish_run();
    end
  end

  localparam logic [143:0] PAT = {16'hBEEF, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210};
  localparam logic [143:0] B6  = 144'(1) << 6;
  localparam logic [143:0] B78 = 144'(1) << 78;

  initial begin
    logic [31:0]  d;
    logic         p, op;
    logic [143:0] oc;

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(out_valid == 0 && inj_pulse == 0, "R1", "outputs after reset", 144'(out_valid), 0);
    chk(inj_count == 0, "R1", "count after reset", 144'(inj_count), 0);
    for (int a = 0; a < 6; a++) begin
      rd_reg(4'(a), d);
      chk(d == 32'h8000_0000, "R1", "field wildcard", 144'(d), 144'h8000_0000);
    end
    for (int a = 6; a < 12; a++) begin
      rd_reg(4'(a), d);
      chk(d == 0, "R1", "control reg zero", 144'(d), 0);
    end
    // R9 unused address
    rd_reg(4'd14, d);
    chk(d == 0, "R9", "unused address", 144'(d), 0);

    // R2 passthrough while disarmed
    req(2'd1, 4'd5, 16'h1234, PAT, 1'b1, p, oc, op);
    chk(!p && oc == PAT && op == 1'b1, "R2", "disarmed passthrough", oc, PAT);

    // R9 program and read back
    wr_reg(4'd9, 32'h40); wr_reg(4'd6, 32'd1); wr_reg(4'd7, 32'd2);
    wr_reg(4'd1, 32'hFF);
    rd_reg(4'd1, d);
    chk(d == 32'h3, "R9", "rank width trimmed", 144'(d), 144'h3);
    wr_reg(4'd1, 32'd1);
    rd_reg(4'd9, d);
    chk(d == 32'h40, "R9", "mask word", 144'(d), 144'h40);

    // R8 nonzero arms
    wr_reg(4'd8, 32'd7);
    rd_reg(4'd8, d);
    chk(d == 1, "R8", "arm reads 1", 144'(d), 1);

    // R3 mismatch then match
    req(2'd2, 4'd5, 16'h1234, PAT, 1'b0, p, oc, op);
    chk(!p && oc == PAT, "R3", "rank mismatch no inject", oc, PAT);
    req(2'd1, 4'd5, 16'h1234, PAT, 1'b0, p, oc, op);
    chk(p && oc == (PAT ^ B6), "R4", "lower half bit 6", oc, PAT ^ B6);
    // R6 one-shot
    rd_reg(4'd8, d);
    chk(d == 0, "R6", "disarmed after one", 144'(d), 0);
    req(2'd1, 4'd5, 16'h1234, PAT, 1'b0, p, oc, op);
    chk(!p && oc == PAT, "R6", "no second injection", oc, PAT);

    // R3 multi-field match
    wr_reg(4'd3, 32'd5); wr_reg(4'd4, 32'h1234); wr_reg(4'd8, 32'd1);
    req(2'd1, 4'd5, 16'h1235, PAT, 1'b0, p, oc, op);
    chk(!p, "R3", "page mismatch", 144'(p), 0);
    req(2'd1, 4'd6, 16'h1234, PAT, 1'b0, p, oc, op);
    chk(!p, "R3", "bank mismatch", 144'(p), 0);

    // R4 upper, both, none
    wr_reg(4'd6, 32'd2);
    req(2'd1, 4'd5, 16'h1234, PAT, 1'b0, p, oc, op);
    chk(p && oc == (PAT ^ B78), "R4", "upper half bit 78", oc, PAT ^ B78);
    wr_reg(4'd6, 32'd3); wr_reg(4'd8, 32'd1);
    req(2'd1, 4'd5, 16'h1234, PAT, 1'b0, p, oc, op);
    chk(p && oc == (PAT ^ B6 ^ B78), "R4", "both halves", oc, PAT ^ B6 ^ B78);
    wr_reg(4'd6, 32'd0); wr_reg(4'd8, 32'd1);
    req(2'd1, 4'd5, 16'h1234, PAT, 1'b0, p, oc, op);
    chk(p && oc == PAT, "R4", "target none counts, no flip", oc, PAT);

    // R5 kinds
    wr_reg(4'd6, 32'd3); wr_reg(4'd7, 32'd4); wr_reg(4'd8, 32'd1);
    req(2'd1, 4'd5, 16'h1234, PAT, 1'b0, p, oc, op);
    chk(p && oc == PAT && op == 1'b1, "R5", "parity only", 144'(op), 1);
    wr_reg(4'd7, 32'd6); wr_reg(4'd8, 32'd1);
    req(2'd1, 4'd5, 16'h1234, PAT, 1'b1, p, oc, op);
    chk(p && oc == (PAT ^ B6 ^ B78) && op == 1'b0, "R5", "data and parity", oc, PAT ^ B6 ^ B78);
    wr_reg(4'd7, 32'd1); wr_reg(4'd8, 32'd1);
    req(2'd1, 4'd5, 16'h1234, PAT, 1'b0, p, oc, op);
    chk(!p && oc == PAT, "R5", "repeat-only kind no inject", 144'(p), 0);

    // R7 repeat until disarmed
    wr_reg(4'd7, 32'd3);
    for (int n = 0; n < 3; n++) begin
      req(2'd1, 4'd5, 16'h1234, PAT, 1'b0, p, oc, op);
      chk(p && oc == (PAT ^ B6 ^ B78), "R7", "repeat inject", oc, PAT ^ B6 ^ B78);
    end
    rd_reg(4'd8, d);
    chk(d == 1, "R7", "still armed", 144'(d), 1);
    wr_reg(4'd8, 32'd0);
    req(2'd1, 4'd5, 16'h1234, PAT, 1'b0, p, oc, op);
    chk(!p && oc == PAT, "R8", "zero disarms", oc, PAT);

    // R8 arm write beats one-shot disarm
    wr_reg(4'd7, 32'd2); wr_reg(4'd8, 32'd1);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'd8; cfg_wdata = 32'd9;
    wr_valid = 1; wr_rank = 2'd1; wr_bank = 4'd5; wr_page = 16'h1234; wr_code = PAT;
    @(negedge clk);
    cfg_we = 0; wr_valid = 0;
    chk(inj_pulse == 1, "R8", "same-cycle inject", 144'(inj_pulse), 1);
    rd_reg(4'd8, d);
    chk(d == 1, "R8", "arm write wins", 144'(d), 1);

    // R10 saturation
    wr_reg(4'd7, 32'd3);
    for (int n = 0; n < 260; n++) req(2'd1, 4'd5, 16'h1234, PAT, 1'b0, p, oc, op);
    @(negedge clk);
    chk(inj_count == 8'd255, "R10", "count saturates", 144'(inj_count), 255);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule